// File: doc/BRIEF.md
# Guest-PC Trace Dispatch Cache

This block sits in the dispatch loop of a binary-translating emulator. Each lookup takes a 64-bit guest program counter and folds it into a 12-bit table index. The index is the XOR of the PC shifted right by one and the PC shifted right by thirteen, keeping the low twelve bits. The block reads the entry at that index. If the entry is valid and its stored guest PC equals the whole requested PC, the block answers with a hit and the host address of the translated trace's entry routine. In every other case it answers with a miss, and software then falls back to decoding and interpreting the guest code.

Software fills the table through an update port. An update either installs a (guest PC, handler) pair at the PC's hashed slot or clears that slot. A single-cycle flush empties the whole table. The answer to a lookup appears one clock after the request. A lookup always sees the table as it stands after the updates and the flush issued in the same cycle.

Top module: `gpl_trace_lookup`

## Requirements
- R1: The slot for a guest PC `p` is `((p >> 1) ^ (p >> 13)) & 4095`. Two PCs with the same slot share one entry. PCs with different slots keep separate entries.
- R2: A lookup hits only when its slot is valid and the stored guest PC equals all 64 bits of the requested PC. A PC that differs in any bit, including bits above the hash range, misses.
- R3: On a hit, `rsp_hit` is 1 and `rsp_handler` carries the handler address that was stored with the matching PC.
- R4: On a miss, `rsp_miss` is 1 and `rsp_handler` is 0. While `rsp_valid` is 1, exactly one of `rsp_hit` and `rsp_miss` is 1.
- R5: `rsp_valid` is 1 in the cycle after a cycle with `lk_req`=1, and 0 after a cycle without it.
- R6: An insert (`upd_en`=1, `upd_kill`=0) writes the PC, the handler and the valid flag at the PC's slot, replacing any earlier entry in that slot.
- R7: An invalidate (`upd_en`=1, `upd_kill`=1) clears the valid flag at the slot of `upd_pc`, whatever PC is stored there.
- R8: A one-cycle `flush` clears every valid flag. Afterwards, every lookup misses until new inserts arrive.
- R9: A lookup issued in the same cycle as an insert to its slot sees the new entry. It hits only if the new PC equals the lookup PC.
- R10: A lookup issued in the same cycle as a flush, or as an invalidate of its slot, misses.
- R11: When a flush and an insert arrive in the same cycle, the inserted entry remains valid after the flush.
- R12: During and right after reset, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0, and every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 64 | Guest PC to look up |
| upd_en | input | 1 | Update request |
| upd_kill | input | 1 | With upd_en: 1 invalidates, 0 inserts |
| upd_pc | input | 64 | Guest PC of the update |
| upd_handler | input | 64 | Handler address stored on insert |
| flush | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_miss | output | 1 | Answer is a miss |
| rsp_handler | output | 64 | Handler address on hit, zero otherwise |

## Verification
The bench builds the block with its default values: 64-bit PC and handler, a 12-bit index, and shift distances of 1 and 13. The full XOR fold is therefore the variant under test. With these values, flipping PC bits 1 and 13 together, or flipping only bit 40, lands a PC in the same slot with a different tag. This lets the bench drive eviction, full-tag rejection and tag-blind invalidation with hand-computed PCs. A run of sixteen PCs that differ only in bits 3 to 6 fills sixteen distinct slots, which checks that separate entries coexist.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

   // update port decode
   typedef enum logic [1:0] {
      UPD_IDLE   = 2'b00,
      UPD_INSERT = 2'b01,
      UPD_KILL   = 2'b11
   } upd_op_e;

   function automatic upd_op_e decode_upd(input logic en, input logic kill);
      if (!en)  return UPD_IDLE;
      if (kill) return UPD_KILL;
      return UPD_INSERT;
   endfunction

endpackage

// File: rtl/gpl_hash.sv
module gpl_hash #(
   parameter int PC_W  = 64,
   parameter int IDX_W = 12,
   parameter int SH_LO = 1,
   parameter int SH_HI = 13
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);

   logic [PC_W-1:0] sh_a;
   logic [PC_W-1:0] sh_b;

   assign sh_a = pc >> SH_LO;

   generate
      if (SH_HI >= PC_W) begin : g_single
         // second term shifted out entirely: plain slice
         assign sh_b = '0;
         assign idx  = sh_a[IDX_W-1:0];
      end else begin : g_fold
         assign sh_b = pc >> SH_HI;
         assign idx  = sh_a[IDX_W-1:0] ^ sh_b[IDX_W-1:0];
      end
   endgenerate

   logic unused_hash_bits;
   assign unused_hash_bits = ^{sh_a, sh_b};

   initial begin
      assert (IDX_W >= 1 && SH_LO + IDX_W <= PC_W)
         else $error("gpl_hash: index window exceeds PC width");
   end

endmodule

// File: rtl/gpl_valid_bits.sv
module gpl_valid_bits #(
   parameter int IDX_W = 12,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld_q
);

   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (clr_all) vld_q <= '0;
         if (clr_en)  vld_q[wr_idx] <= 1'b0;
         if (set_en)  vld_q[wr_idx] <= 1'b1;   // set after a flush survives
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_vld_q <= 1'b0;
      else        rd_vld_q <= vld_q[rd_idx];
   end

   p_flush_empties_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_all && !set_en |=> vld_q == '0);

   p_set_sticks_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> vld_q[$past(wr_idx)]);

   p_clear_slot_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !vld_q[$past(wr_idx)]);

endmodule

// File: rtl/gpl_entry_store.sv
module gpl_entry_store #(
   parameter int IDX_W = 12,
   parameter int TAG_W = 64,
   parameter int HND_W = 64,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [HND_W-1:0] wr_hnd,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag_q,
   output logic [HND_W-1:0] rd_hnd_q
);

   logic [TAG_W-1:0] tag_mem [DEPTH];
   logic [HND_W-1:0] hnd_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx] <= wr_tag;
         hnd_mem[wr_idx] <= wr_hnd;
      end
      rd_tag_q <= tag_mem[rd_idx];
      rd_hnd_q <= hnd_mem[rd_idx];
   end

endmodule

// File: rtl/gpl_trace_lookup.sv
module gpl_trace_lookup
   import gpl_pkg::*;
#(
   parameter int PC_W  = 64,
   parameter int HND_W = 64,
   parameter int IDX_W = 12,
   parameter int SH_LO = 1,
   parameter int SH_HI = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [PC_W-1:0]  lk_pc,
   input  logic             upd_en,
   input  logic             upd_kill,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic [HND_W-1:0] upd_handler,
   input  logic             flush,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic [HND_W-1:0] rsp_handler
);

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 16)
         else $error("gpl_trace_lookup: IDX_W out of range");
      assert (SH_LO < SH_HI)
         else $error("gpl_trace_lookup: shifts must be ordered");
   end

   // index paths: lookup and update hashed with the same fold
   localparam int N_PORT = 2;
   logic [PC_W-1:0]  hash_in  [N_PORT];
   logic [IDX_W-1:0] hash_out [N_PORT];

   assign hash_in[0] = lk_pc;
   assign hash_in[1] = upd_pc;

   generate
      for (genvar gi = 0; gi < N_PORT; gi++) begin : g_hash
         gpl_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .SH_LO(SH_LO), .SH_HI(SH_HI)) hash_i (
            .pc  (hash_in[gi]),
            .idx (hash_out[gi])
         );
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;
   assign lk_idx = hash_out[0];
   assign up_idx = hash_out[1];

   upd_op_e op;
   logic    do_ins;
   logic    do_kill;
   logic    same_idx;

   assign op       = decode_upd(upd_en, upd_kill);
   assign do_ins   = (op == UPD_INSERT);
   assign do_kill  = (op == UPD_KILL);
   assign same_idx = (lk_idx == up_idx);

   // storage
   logic             rd_vld;
   logic [PC_W-1:0]  rd_tag;
   logic [HND_W-1:0] rd_hnd;

   gpl_valid_bits #(.IDX_W(IDX_W)) vld_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (flush),
      .set_en   (do_ins),
      .clr_en   (do_kill),
      .wr_idx   (up_idx),
      .rd_idx   (lk_idx),
      .rd_vld_q (rd_vld)
   );

   gpl_entry_store #(.IDX_W(IDX_W), .TAG_W(PC_W), .HND_W(HND_W)) store_i (
      .clk      (clk),
      .wr_en    (do_ins),
      .wr_idx   (up_idx),
      .wr_tag   (upd_pc),
      .wr_hnd   (upd_handler),
      .rd_idx   (lk_idx),
      .rd_tag_q (rd_tag),
      .rd_hnd_q (rd_hnd)
   );

   // response stage: request context plus same-cycle update bypass
   logic             s_req;
   logic [PC_W-1:0]  s_pc;
   logic             s_fwd;
   logic             s_drop;
   logic [PC_W-1:0]  s_fwd_tag;
   logic [HND_W-1:0] s_fwd_hnd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_req     <= 1'b0;
         s_pc      <= '0;
         s_fwd     <= 1'b0;
         s_drop    <= 1'b0;
         s_fwd_tag <= '0;
         s_fwd_hnd <= '0;
      end else begin
         s_req  <= lk_req;
         s_pc   <= lk_pc;
         s_fwd  <= lk_req && do_ins && same_idx;
         s_drop <= flush || (do_kill && same_idx);
         if (do_ins) begin
            s_fwd_tag <= upd_pc;
            s_fwd_hnd <= upd_handler;
         end
      end
   end

   logic             eff_vld;
   logic [PC_W-1:0]  eff_tag;
   logic [HND_W-1:0] eff_hnd;
   logic             match;

   always_comb begin
      if (s_fwd) begin
         eff_vld = 1'b1;
         eff_tag = s_fwd_tag;
         eff_hnd = s_fwd_hnd;
      end else begin
         eff_vld = rd_vld && !s_drop;
         eff_tag = rd_tag;
         eff_hnd = rd_hnd;
      end
   end

   assign match       = eff_vld && (eff_tag == s_pc);
   assign rsp_valid   = s_req;
   assign rsp_hit     = s_req && match;
   assign rsp_miss    = s_req && !match;
   assign rsp_handler = rsp_hit ? eff_hnd : '0;

   // checks against port behaviour
   p_resp_follows_req_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);

   p_no_spurious_resp_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss);

   p_hit_miss_excl_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

   p_miss_zero_hnd_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> rsp_handler == '0);

   p_fwd_insert_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_req && upd_en && !upd_kill && upd_pc == lk_pc
      |=> rsp_hit && rsp_handler == $past(upd_handler));

   p_kill_same_cycle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_req && upd_en && upd_kill && same_idx |=> rsp_miss);

   p_flush_same_cycle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      lk_req && flush && !(do_ins && same_idx) |=> rsp_miss);

endmodule

// File: tb/gpl_trace_lookup_tb_top.sv
module gpl_trace_lookup_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_req;
   logic [63:0] lk_pc;
   logic        upd_en;
   logic        upd_kill;
   logic [63:0] upd_pc;
   logic [63:0] upd_handler;
   logic        flush;
   logic        rsp_valid;
   logic        rsp_hit;
   logic        rsp_miss;
   logic [63:0] rsp_handler;

   always #2 clk = ~clk;   // 250 MHz

   gpl_trace_lookup dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_req      (lk_req),
      .lk_pc       (lk_pc),
      .upd_en      (upd_en),
      .upd_kill    (upd_kill),
      .upd_pc      (upd_pc),
      .upd_handler (upd_handler),
      .flush       (flush),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .rsp_miss    (rsp_miss),
      .rsp_handler (rsp_handler)
   );

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [63:0] PC_A   = 64'h0000_0040_1234_5678;
   localparam logic [63:0] ALI_LO = 64'h0000_0000_0000_2002; // bits 13 and 1: same slot
   localparam logic [63:0] ALI_HI = 64'h0000_0100_0000_0000; // bit 40: same slot
   localparam logic [63:0] PC_B   = PC_A ^ ALI_LO;
   localparam logic [63:0] PC_C   = PC_A ^ 64'h4;             // slot differs by 2
   localparam logic [63:0] PC_D   = 64'h0000_0000_0077_0010;
   localparam logic [63:0] PC_E   = 64'h0000_0000_00AB_C000;
   localparam logic [63:0] PC_F   = 64'hFFFF_0000_0000_1230;

   task automatic idle();
      lk_req = 0; lk_pc = '0; upd_en = 0; upd_kill = 0;
      upd_pc = '0; upd_handler = '0; flush = 0;
   endtask

   // drive one cycle at a falling edge; on return the response is visible
   task automatic cyc(input logic lk, input logic [63:0] lpc,
                      input logic ue, input logic uk, input logic [63:0] upc,
                      input logic [63:0] uh, input logic fl);
      lk_req = lk; lk_pc = lpc; upd_en = ue; upd_kill = uk;
      upd_pc = upc; upd_handler = uh; flush = fl;
      @(negedge clk);
      idle();
   endtask

   task automatic look(input logic [63:0] pc);
      cyc(1'b1, pc, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic put(input logic [63:0] pc, input logic [63:0] h);
      cyc(1'b0, '0, 1'b1, 1'b0, pc, h, 1'b0);
   endtask

   task automatic drop(input logic [63:0] pc);
      cyc(1'b0, '0, 1'b1, 1'b1, pc, '0, 1'b0);
   endtask

   task automatic expect_rsp(input string rq, input logic eh, input logic [63:0] ehnd);
      logic [63:0] want;
      want = eh ? ehnd : 64'h0;
      n_chk++;
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh || rsp_handler !== want) begin
         n_bad++;
         $display("FAIL %s: valid=%b hit=%b miss=%b hnd=%h, expected valid=1 hit=%b miss=%b hnd=%h",
                  rq, rsp_valid, rsp_hit, rsp_miss, rsp_handler, eh, !eh, want);
      end
   endtask

   task automatic expect_quiet(input string rq);
      n_chk++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: valid=%b hit=%b miss=%b, expected all 0",
                  rq, rsp_valid, rsp_hit, rsp_miss);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      expect_quiet("R12 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      expect_quiet("R12 after reset");
      look(PC_A);
      expect_rsp("R12 empty table", 1'b0, '0);
   endtask

   task automatic t_basic_hit();
      put(PC_A, 64'h1111_2222_3333_4444);
      look(PC_A);
      expect_rsp("R3 hit returns handler", 1'b1, 64'h1111_2222_3333_4444);
      @(negedge clk);
      expect_quiet("R5 no answer without request");
   endtask

   task automatic t_alias();
      look(PC_B);
      expect_rsp("R2 alias bits 13/1 misses", 1'b0, '0);
      look(PC_A ^ ALI_HI);
      expect_rsp("R2 alias bit 40 misses", 1'b0, '0);
      put(PC_B, 64'h5555_6666_7777_8888);
      look(PC_B);
      expect_rsp("R6 replacing entry hits", 1'b1, 64'h5555_6666_7777_8888);
      look(PC_A);
      expect_rsp("R1 shared slot evicted old PC", 1'b0, '0);
   endtask

   task automatic t_distinct();
      put(PC_C, 64'h0000_0000_C0DE_0003);
      look(PC_B);
      expect_rsp("R1 separate slot untouched", 1'b1, 64'h5555_6666_7777_8888);
      look(PC_C);
      expect_rsp("R1 second slot hits", 1'b1, 64'h0000_0000_C0DE_0003);
   endtask

   task automatic t_invalidate();
      drop(PC_B ^ ALI_HI);
      look(PC_B);
      expect_rsp("R7 invalidate ignores tag", 1'b0, '0);
      look(PC_C);
      expect_rsp("R7 other slot kept", 1'b1, 64'h0000_0000_C0DE_0003);
   endtask

   task automatic t_flush();
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1);
      look(PC_C);
      expect_rsp("R8 flush empties table", 1'b0, '0);
   endtask

   task automatic t_fill_many();
      for (int i = 0; i < 16; i++)
         put(64'h8000_0000 | (64'(i) << 3), 64'hABCD_0000_0000_0000 | 64'(i));
      for (int i = 0; i < 16; i++) begin
         look(64'h8000_0000 | (64'(i) << 3));
         expect_rsp("R1 sixteen slots coexist", 1'b1, 64'hABCD_0000_0000_0000 | 64'(i));
      end
   endtask

   task automatic t_forward();
      cyc(1'b1, PC_D, 1'b1, 1'b0, PC_D, 64'h0000_0000_0D0D_0004, 1'b0);
      expect_rsp("R9 same-cycle insert forwarded", 1'b1, 64'h0000_0000_0D0D_0004);
      cyc(1'b1, PC_D, 1'b1, 1'b0, PC_D ^ ALI_HI, 64'h0000_0000_0BAD_0000, 1'b0);
      expect_rsp("R9 forwarded tag mismatch misses", 1'b0, '0);
      put(PC_D, 64'h0000_0000_0D0D_0005);
      look(PC_D);
      expect_rsp("R6 reinsert hits", 1'b1, 64'h0000_0000_0D0D_0005);
   endtask

   task automatic t_same_cycle_clear();
      cyc(1'b1, PC_D, 1'b1, 1'b1, PC_D, '0, 1'b0);
      expect_rsp("R10 same-cycle invalidate misses", 1'b0, '0);
      put(PC_E, 64'h0000_0000_0E0E_0006);
      cyc(1'b1, PC_E, 1'b0, 1'b0, '0, '0, 1'b1);
      expect_rsp("R10 same-cycle flush misses", 1'b0, '0);
   endtask

   task automatic t_flush_insert();
      cyc(1'b0, '0, 1'b1, 1'b0, PC_F, 64'h0000_0000_0F0F_0007, 1'b1);
      look(PC_F);
      expect_rsp("R11 insert survives flush", 1'b1, 64'h0000_0000_0F0F_0007);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      idle();
      @(negedge clk);
      t_reset();
      t_basic_hit();
      t_alias();
      t_distinct();
      t_invalidate();
      t_flush();
      t_fill_many();
      t_forward();
      t_same_cycle_clear();
      t_flush_insert();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule